// File: doc/BRIEF.md
# Bus-Master DMA Channel Controller

This block is the data-movement channel that sits beside a SCSI protocol core in a host adapter. Software programs a start byte count, a start memory address and a start descriptor-list address through a word-wide register port, then issues a START command. START copies the start values into separate working counters, so the programmed values survive the transfer and a restart needs only one more command write.

During a transfer the SCSI core asks to move a number of bytes in a given direction. The channel accepts the request in the same cycle. It returns a granted length that is clipped to the bytes still owed, or zero if the direction does not match the programmed direction. It then lowers the working count, advances the working address, and sets a done flag once the count is exhausted. The memory address it gives for each burst is the start-address register. A completion signal from the core forces the count to zero and sets done.

Status flags are cleared in one of two ways, chosen by a bit in a bus-control register. In one mode software writes a 1 to each flag it wants cleared. In the other, reading status clears the flags. The core's interrupt line appears live in bit 4 of every status read and is never stored.

Top module: `bm_dma_channel`

## Requirements
- R1: Register index map on `reg_addr`: 0 command, 1 start count, 2 start address, 3 working count, 4 working address, 5 status, 6 start list address, 7 working list address, 8 bus control. Indexes 0, 1, 2, 6 and 8 store the written word and read it back. Writes to indexes 3, 4 and 7 leave those registers unchanged.
- R2: Command bits [1:0] select the operation: 0 idle, 1 flush, 2 abort, 3 start. Bit 7 is the direction (1 = device to memory). A command write with operation idle drives `dma_en` low from the next cycle, and operation start drives it high. Flush and abort leave `dma_en` and all counters unchanged.
- R3: START loads working count from start count, working address from start address and working list address from start list address, and clears status bits [5:0], all visible in the next cycle.
- R4: Writing operation abort makes `abort_req` high for exactly the one cycle after the write.
- R5: Status bits: 1 error, 2 abort, 3 done, 4 core interrupt. With bus-control bit 12 at 0, a status write clears bits 1, 2 and 3 wherever the written value has a 1, and leaves the other bits unchanged.
- R6: With bus-control bit 12 at 1, status writes have no effect. A status read returns the current value and clears bits 1, 2 and 3 in the following cycle.
- R7: A status read returns bit 4 set whenever `scsi_irq` is high. The bit is not stored.
- R8: A transfer request whose `xfer_dir` differs from command bit 7 is accepted with `xfer_grant` 0 and changes no counter or flag.
- R9: A matching request is granted min(`xfer_len`, working count). The working count drops by the grant and the working address rises by it. Done (status bit 3) is set when the count left is 0.
- R10: `xfer_addr` equals the start-address register, not the working address.
- R11: After reset: command 0, working count 0, working address 0xFFFFFFFF, status 0, working list address 0xFFFFFFFD, `dma_en` 0, `abort_req` 0.
- R12: A pulse on `cmd_done` forces the working count to 0 and sets done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for read-clear) |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| scsi_irq | input | 1 | Interrupt level from the SCSI core |
| cmd_done | input | 1 | Command-completion pulse from the SCSI core |
| xfer_valid | input | 1 | Transfer request valid |
| xfer_dir | input | 1 | Requested direction, 1 = device to memory |
| xfer_len | input | 32 | Requested byte count |
| xfer_ready | output | 1 | Request accepted this cycle |
| xfer_grant | output | 32 | Granted byte count, same cycle as ready |
| xfer_addr | output | 32 | Memory address for the burst |
| dma_en | output | 1 | Channel enabled |
| abort_req | output | 1 | One-cycle request to cancel the active request |

## Verification
The assertions check on every cycle that the enable holds without a command write, that a grant never exceeds the remaining count or the request, that a rejected request leaves the counters still, that START and completion land the right counter values one cycle later, and that status writes in read-clear mode change nothing. Only the bench scenarios can show the actual register values: the reset contents, the clipped grant sequence down to zero, which flags each clear mode removes, the live interrupt bit disappearing, and the one-cycle width of the abort pulse.

// File: rtl/bm_dma_pkg.sv
package bm_dma_pkg;
  localparam int unsigned IDX_W = 4;

  typedef enum logic [IDX_W-1:0] {
    IDX_CMD  = 4'd0,
    IDX_SCNT = 4'd1,
    IDX_SADR = 4'd2,
    IDX_WCNT = 4'd3,
    IDX_WADR = 4'd4,
    IDX_STAT = 4'd5,
    IDX_SLST = 4'd6,
    IDX_WLST = 4'd7,
    IDX_BCTL = 4'd8
  } reg_idx_e;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_FLUSH = 2'd1,
    OP_ABORT = 2'd2,
    OP_START = 2'd3
  } dma_op_e;

  localparam int unsigned CMD_DIR_BIT = 7;
  localparam int unsigned STAT_W      = 6;
  localparam int unsigned ST_ERR      = 1;
  localparam int unsigned ST_ABT      = 2;
  localparam int unsigned ST_DONE     = 3;
  localparam int unsigned ST_SINT     = 4;
  localparam int unsigned MODE_BIT    = 12;
endpackage

// File: rtl/bm_dma_cmd.sv
module bm_dma_cmd
  import bm_dma_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cmd_q,
  output logic          start_now,
  output logic          dma_en,
  output logic          abort_req
);
  dma_op_e       op_w;
  logic [DW-1:0] cmd_d;
  logic          en_d;
  logic          abort_d;

  assign op_w      = dma_op_e'(wdata[1:0]);
  assign start_now = cmd_wr && (op_w == OP_START);

  always_comb begin
    cmd_d   = cmd_q;
    en_d    = dma_en;
    abort_d = 1'b0;
    if (cmd_wr) begin
      cmd_d = wdata;
      case (op_w)
        OP_IDLE:  en_d    = 1'b0;
        OP_START: en_d    = 1'b1;
        OP_ABORT: abort_d = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      dma_en    <= 1'b0;
      abort_req <= 1'b0;
    end else begin
      cmd_q     <= cmd_d;
      dma_en    <= en_d;
      abort_req <= abort_d;
    end
  end

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> $stable(dma_en)); // R2
  AST_ABORT_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> !abort_req); // R4
endmodule

// File: rtl/bm_dma_xfer.sv
module bm_dma_xfer #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xfer_valid,
  input  logic          xfer_dir,
  input  logic [DW-1:0] xfer_len,
  input  logic          cmd_dir,
  input  logic [DW-1:0] wcnt,
  output logic          xfer_ready,
  output logic [DW-1:0] xfer_grant,
  output logic          accept,
  output logic [DW-1:0] cnt_left
);
  logic dir_ok;

  assign dir_ok     = (xfer_dir == cmd_dir);
  assign xfer_ready = xfer_valid;
  assign accept     = xfer_valid && dir_ok;

  always_comb begin
    xfer_grant = '0;
    if (dir_ok) begin
      xfer_grant = (xfer_len < wcnt) ? xfer_len : wcnt;
    end
    cnt_left = wcnt - xfer_grant;
  end

  AST_GRANT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (xfer_grant <= wcnt) && (xfer_grant <= xfer_len)); // R9
endmodule

// File: rtl/bm_dma_status.sv
module bm_dma_status
  import bm_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_wr,
  input  logic [STAT_W-1:0] wdata,
  input  logic              stat_rd,
  input  logic              rd_clear_mode,
  input  logic              set_done,
  input  logic              start_clr,
  output logic [STAT_W-1:0] stat_q
);
  localparam logic [STAT_W-1:0] CLR_MASK =
    STAT_W'((1 << ST_ERR) | (1 << ST_ABT) | (1 << ST_DONE));

  logic [STAT_W-1:0] stat_d;

  always_comb begin
    stat_d = stat_q;
    if (stat_wr && !rd_clear_mode) stat_d = stat_d & ~(wdata & CLR_MASK);
    if (stat_rd && rd_clear_mode)  stat_d = stat_d & ~CLR_MASK;
    if (set_done)                  stat_d[ST_DONE] = 1'b1;
    if (start_clr)                 stat_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  AST_STAT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && rd_clear_mode && !stat_rd && !set_done && !start_clr)
      |=> $stable(stat_q)); // R6
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_clr |=> (stat_q == '0)); // R3
endmodule

// File: rtl/bm_dma_channel.sv
module bm_dma_channel
  import bm_dma_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter logic [31:0] WADR_RST = 32'hFFFF_FFFF,
  parameter logic [31:0] WLST_RST = 32'hFFFF_FFFD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [IDX_W-1:0] reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             scsi_irq,
  input  logic             cmd_done,
  input  logic             xfer_valid,
  input  logic             xfer_dir,
  input  logic [DW-1:0]    xfer_len,
  output logic             xfer_ready,
  output logic [DW-1:0]    xfer_grant,
  output logic [DW-1:0]    xfer_addr,
  output logic             dma_en,
  output logic             abort_req
);
  localparam logic [DW-1:0] WADR_INIT = DW'(WADR_RST);
  localparam logic [DW-1:0] WLST_INIT = DW'(WLST_RST);

  logic [DW-1:0] scnt_q, sadr_q, slst_q, wcnt_q, wadr_q, wlst_q, bctl_q;
  logic [DW-1:0] scnt_d, sadr_d, slst_d, wcnt_d, wadr_d, wlst_d, bctl_d;
  logic [DW-1:0] cmd_q, cnt_left;
  logic [STAT_W-1:0] stat_q;
  logic start_now, accept, set_done, stat_rd, stat_wr;

  assign stat_wr = reg_wr && (reg_addr == IDX_STAT);
  assign stat_rd = reg_rd && (reg_addr == IDX_STAT);

  bm_dma_cmd #(.DW(DW)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (reg_wr && (reg_addr == IDX_CMD)),
    .wdata     (reg_wdata),
    .cmd_q     (cmd_q),
    .start_now (start_now),
    .dma_en    (dma_en),
    .abort_req (abort_req)
  );

  bm_dma_xfer #(.DW(DW)) u_xfer (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_valid (xfer_valid),
    .xfer_dir   (xfer_dir),
    .xfer_len   (xfer_len),
    .cmd_dir    (cmd_q[CMD_DIR_BIT]),
    .wcnt       (wcnt_q),
    .xfer_ready (xfer_ready),
    .xfer_grant (xfer_grant),
    .accept     (accept),
    .cnt_left   (cnt_left)
  );

  assign set_done = cmd_done || (accept && (cnt_left == '0));

  bm_dma_status u_stat (
    .clk           (clk),
    .rst_n         (rst_n),
    .stat_wr       (stat_wr),
    .wdata         (reg_wdata[STAT_W-1:0]),
    .stat_rd       (stat_rd),
    .rd_clear_mode (bctl_q[MODE_BIT]),
    .set_done      (set_done),
    .start_clr     (start_now),
    .stat_q        (stat_q)
  );

  assign xfer_addr = sadr_q;

  always_comb begin
    scnt_d = scnt_q;
    sadr_d = sadr_q;
    slst_d = slst_q;
    bctl_d = bctl_q;
    wcnt_d = wcnt_q;
    wadr_d = wadr_q;
    wlst_d = wlst_q;
    if (reg_wr) begin
      case (reg_addr)
        IDX_SCNT: scnt_d = reg_wdata;
        IDX_SADR: sadr_d = reg_wdata;
        IDX_SLST: slst_d = reg_wdata;
        IDX_BCTL: bctl_d = reg_wdata;
        default:  ;
      endcase
    end
    if (accept) begin
      wcnt_d = cnt_left;
      wadr_d = wadr_q + xfer_grant;
    end
    if (cmd_done) wcnt_d = '0;
    if (start_now) begin
      wcnt_d = scnt_q;
      wadr_d = sadr_q;
      wlst_d = slst_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scnt_q <= '0;
      sadr_q <= '0;
      slst_q <= '0;
      bctl_q <= '0;
      wcnt_q <= '0;
      wadr_q <= WADR_INIT;
      wlst_q <= WLST_INIT;
    end else begin
      scnt_q <= scnt_d;
      sadr_q <= sadr_d;
      slst_q <= slst_d;
      bctl_q <= bctl_d;
      wcnt_q <= wcnt_d;
      wadr_q <= wadr_d;
      wlst_q <= wlst_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      IDX_CMD:  reg_rdata = cmd_q;
      IDX_SCNT: reg_rdata = scnt_q;
      IDX_SADR: reg_rdata = sadr_q;
      IDX_WCNT: reg_rdata = wcnt_q;
      IDX_WADR: reg_rdata = wadr_q;
      IDX_STAT: begin
        reg_rdata[STAT_W-1:0] = stat_q;
        if (scsi_irq) reg_rdata[ST_SINT] = 1'b1;
      end
      IDX_SLST: reg_rdata = slst_q;
      IDX_WLST: reg_rdata = wlst_q;
      IDX_BCTL: reg_rdata = bctl_q;
      default:  ;
    endcase
  end

  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start_now |=> (wcnt_q == $past(scnt_q)) && (wadr_q == $past(sadr_q))
                  && (wlst_q == $past(slst_q))); // R3
  AST_CMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && !start_now) |=> (wcnt_q == '0) && stat_q[ST_DONE]); // R12
  AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && (xfer_dir != cmd_q[CMD_DIR_BIT]) && !start_now && !cmd_done)
      |=> $stable(wcnt_q) && $stable(wadr_q)); // R8
  AST_WORK_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == IDX_WCNT) && !xfer_valid && !cmd_done)
      |=> $stable(wcnt_q)); // R1
endmodule

// File: tb/tb_bm_dma_channel.sv
module tb_bm_dma_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        scsi_irq = 1'b0, cmd_done = 1'b0;
  logic        xfer_valid = 1'b0, xfer_dir = 1'b0;
  logic [31:0] xfer_len = '0;
  logic        xfer_ready;
  logic [31:0] xfer_grant, xfer_addr;
  logic        dma_en, abort_req;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bm_dma_channel dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scsi_irq(scsi_irq), .cmd_done(cmd_done), .xfer_valid(xfer_valid),
    .xfer_dir(xfer_dir), .xfer_len(xfer_len), .xfer_ready(xfer_ready),
    .xfer_grant(xfer_grant), .xfer_addr(xfer_addr), .dma_en(dma_en),
    .abort_req(abort_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(posedge clk); @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic xfer(input logic dir, input logic [31:0] len,
                      output logic rdy, output logic [31:0] g, output logic [31:0] ad);
    xfer_valid = 1'b1; xfer_dir = dir; xfer_len = len;
    #1 rdy = xfer_ready; g = xfer_grant; ad = xfer_addr;
    @(posedge clk); @(negedge clk);
    xfer_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    #1;
    chk("R11 dma_en", {31'd0, dma_en}, 32'd0);
    chk("R11 abort_req", {31'd0, abort_req}, 32'd0);
    rd(4'd0, v); chk("R11 command", v, 32'd0);
    rd(4'd3, v); chk("R11 working count", v, 32'd0);
    rd(4'd4, v); chk("R11 working address", v, 32'hFFFF_FFFF);
    rd(4'd5, v); chk("R11 status", v, 32'd0);
    rd(4'd7, v); chk("R11 working list", v, 32'hFFFF_FFFD);
  endtask

  task automatic t_regmap;
    logic [31:0] v;
    wr(4'd1, 32'h100); wr(4'd2, 32'h2000); wr(4'd6, 32'h3000);
    rd(4'd1, v); chk("R1 start count", v, 32'h100);
    rd(4'd2, v); chk("R1 start address", v, 32'h2000);
    rd(4'd6, v); chk("R1 start list", v, 32'h3000);
    wr(4'd3, 32'h55); wr(4'd4, 32'h66); wr(4'd7, 32'h77);
    rd(4'd3, v); chk("R1 working count write dropped", v, 32'd0);
    rd(4'd4, v); chk("R1 working address write dropped", v, 32'hFFFF_FFFF);
    rd(4'd7, v); chk("R1 working list write dropped", v, 32'hFFFF_FFFD);
  endtask

  task automatic t_start;
    logic [31:0] v;
    wr(4'd0, 32'h3);
    chk("R2 start enables", {31'd0, dma_en}, 32'd1);
    rd(4'd3, v); chk("R3 working count loaded", v, 32'h100);
    rd(4'd4, v); chk("R3 working address loaded", v, 32'h2000);
    rd(4'd7, v); chk("R3 working list loaded", v, 32'h3000);
    rd(4'd5, v); chk("R3 status cleared", v, 32'd0);
  endtask

  task automatic t_clip;
    logic r; logic [31:0] g, a, v;
    xfer(1'b0, 32'h40, r, g, a);
    chk("R9 ready", {31'd0, r}, 32'd1);
    chk("R9 grant full", g, 32'h40);
    chk("R10 burst address", a, 32'h2000);
    rd(4'd3, v); chk("R9 count after first", v, 32'hC0);
    rd(4'd4, v); chk("R9 address after first", v, 32'h2040);
    rd(4'd5, v); chk("R9 no done yet", v, 32'd0);
    xfer(1'b0, 32'h200, r, g, a);
    chk("R9 grant clipped", g, 32'hC0);
    chk("R10 burst address unchanged", a, 32'h2000);
    rd(4'd3, v); chk("R9 count zero", v, 32'd0);
    rd(4'd4, v); chk("R9 address end", v, 32'h2100);
    rd(4'd5, v); chk("R9 done set", v, 32'h8);
  endtask

  task automatic t_mismatch;
    logic r; logic [31:0] g, a, v;
    wr(4'd1, 32'h20); wr(4'd0, 32'h3);
    xfer(1'b1, 32'h4, r, g, a);
    chk("R8 ready on reject", {31'd0, r}, 32'd1);
    chk("R8 grant zero", g, 32'd0);
    rd(4'd3, v); chk("R8 count held", v, 32'h20);
    rd(4'd4, v); chk("R8 address held", v, 32'h2000);
    rd(4'd5, v); chk("R8 no done", v, 32'd0);
  endtask

  task automatic t_complete;
    logic [31:0] v;
    cmd_done = 1'b1; @(posedge clk); @(negedge clk); cmd_done = 1'b0;
    rd(4'd3, v); chk("R12 count forced zero", v, 32'd0);
    rd(4'd5, v); chk("R12 done set", v, 32'h8);
  endtask

  task automatic t_wclear;
    logic [31:0] v;
    wr(4'd5, 32'h0);  rd(4'd5, v); chk("R5 zero write keeps", v, 32'h8);
    wr(4'd5, 32'h36); rd(4'd5, v); chk("R5 other bits keep done", v, 32'h8);
    rd(4'd5, v); chk("R5 read does not clear in mode 0", v, 32'h8);
    wr(4'd5, 32'h8);  rd(4'd5, v); chk("R5 done cleared", v, 32'h0);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    cmd_done = 1'b1; @(posedge clk); @(negedge clk); cmd_done = 1'b0;
    scsi_irq = 1'b1;
    rd(4'd5, v); chk("R7 live interrupt", v, 32'h18);
    scsi_irq = 1'b0;
    rd(4'd5, v); chk("R7 interrupt not stored", v, 32'h08);
  endtask

  task automatic t_rclear;
    logic [31:0] v;
    wr(4'd8, 32'h1000);
    rd(4'd8, v); chk("R6 bus control readback", v, 32'h1000);
    wr(4'd5, 32'hFF);
    rd(4'd5, v); chk("R6 write ignored, read returns", v, 32'h8);
    rd(4'd5, v); chk("R6 read cleared", v, 32'h0);
    wr(4'd8, 32'h0);
  endtask

  task automatic t_dir1;
    logic r; logic [31:0] g, a, v;
    wr(4'd1, 32'h10); wr(4'd0, 32'h83);
    xfer(1'b1, 32'h8, r, g, a);
    chk("R9 device-to-memory grant", g, 32'h8);
    rd(4'd4, v); chk("R9 address advanced", v, 32'h2008);
    xfer(1'b0, 32'h8, r, g, a);
    chk("R8 opposite direction rejected", g, 32'd0);
    rd(4'd3, v); chk("R8 count held", v, 32'h8);
  endtask

  task automatic t_cmdops;
    logic [31:0] v;
    wr(4'd0, 32'h81);
    chk("R2 flush keeps enable", {31'd0, dma_en}, 32'd1);
    chk("R4 flush no abort", {31'd0, abort_req}, 32'd0);
    rd(4'd3, v); chk("R2 flush keeps count", v, 32'h8);
    wr(4'd0, 32'h82);
    chk("R4 abort pulse", {31'd0, abort_req}, 32'd1);
    chk("R2 abort keeps enable", {31'd0, dma_en}, 32'd1);
    @(negedge clk);
    chk("R4 abort one cycle", {31'd0, abort_req}, 32'd0);
    wr(4'd0, 32'h80);
    chk("R2 idle disables", {31'd0, dma_en}, 32'd0);
    rd(4'd0, v); chk("R2 command readback", v, 32'h80);
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_start();
    t_clip();
    t_mismatch();
    t_complete();
    t_wclear();
    t_irq();
    t_rclear();
    t_dir1();
    t_cmdops();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule